// File: doc/BRIEF.md
# Symmetric Saturating Sample Quantiser

This block turns a wide signed fixed-point measurement sample into a 16-bit signed code and raises a flag when the code sits at a range limit. The incoming value is already scaled so that one unit of its integer part equals one output code step. The bits below the binary point are fractions of a step. The block rounds the value to the nearest whole code. Halves go away from zero. It then clamps the result to a range that is the same size on both sides of zero, ±32767. Because of this, the most negative two's-complement code, −32768, never reaches the output.

Saturation is reported inclusively. A sample that rounds to exactly +32767 or −32767 raises the flag, the same as one that rounds beyond the limit. Each accepted sample gives a registered result exactly one clock later, marked by a valid strobe. Cycles without an input strobe leave the last code and flag in place.

Top module: `sym_sat_quantiser`

## Requirements
- R1: `out_code` is a 16-bit two's-complement value. For a sample whose rounded value r satisfies −32767 < r < 32767, `out_code` equals r.
- R2: `out_code` never takes the value −32768 (16'h8000), for any input including 32'h80000000.
- R3: `in_sample` is a 32-bit two's-complement number with 8 fractional bits (bits 7:0). Rounding picks the nearest integer. A fraction of exactly 0x80 (one half) rounds away from zero for both signs, so +2.5 gives 3 and −2.5 gives −3.
- R4: When the rounded value is ≥ +32767, `out_code` is +32767 and `out_sat` is 1. This includes a rounded value of exactly +32767.
- R5: When the rounded value is ≤ −32767, `out_code` is −32767 and `out_sat` is 1. This includes a rounded value of exactly −32767.
- R6: For a rounded value strictly inside the limits, `out_sat` is 0, and `out_code` times 256 differs from `in_sample` by at most 128.
- R7: A sample presented with `in_valid` high at a rising clock edge appears on `out_code`/`out_sat` after that edge, with `out_valid` high for one cycle per accepted sample.
- R8: A clock edge with `in_valid` low drives `out_valid` to 0 and leaves `out_code` and `out_sat` unchanged, whatever `in_sample` holds.
- R9: A rising edge with `rst_n` low clears `out_code`, `out_sat` and `out_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample strobe; `in_sample` is taken when high |
| in_sample | input | 32 | Signed sample, 8 fractional bits |
| out_valid | output | 1 | High for the cycle after an accepted sample |
| out_code | output | 16 | Signed quantised code, range ±32767 |
| out_sat | output | 1 | Code sits at a limit (inclusive) |

## Verification
The assertions take for granted that `in_valid` and `in_sample` are never unknown once reset has released. The combinational checks also skip any cycle in which the sample is unknown. The bench holds these inputs at defined values from time zero. It changes them only on falling clock edges, so each rising edge sees a settled sample.

Stimulus stays inside the 32-bit input range but covers both ends of it. It also covers:
- every fractional pattern near zero;
- every half-step tie over several hundred codes;
- dense windows around the positive and negative clamp thresholds.

// File: rtl/sq_pkg.sv
// Package: sq_pkg
// Shared widths for the saturating quantiser. The input has IN_W bits with
// FRAC_W of them fractional. The output code is OUT_W bits, clamped to a
// range that is the same size on both sides of zero.
package sq_pkg;
    localparam int SQ_IN_W   = 32;
    localparam int SQ_FRAC_W = 8;
    localparam int SQ_OUT_W  = 16;
endpackage

// File: rtl/sq_round.sv
// Module: sq_round
// Rounds a signed fixed-point sample to the nearest integer. Halves go away
// from zero. The magnitude is taken first, half a step is added, and the
// fraction is dropped, so both signs behave the same way.
// Assumes FRAC_W >= 1 and IN_W > FRAC_W. The output is wide enough to hold
// the rounded magnitude of the most negative input.
module sq_round #(
    parameter int IN_W   = 32,
    parameter int FRAC_W = 8,
    parameter int RW     = IN_W - FRAC_W + 2
) (
    input  logic [IN_W-1:0] sample_i,
    output logic [RW-1:0]   rnd_o
);
    localparam int MW   = IN_W + 1;
    localparam int HALF = 2 ** (FRAC_W - 1);

    logic          neg;
    logic [MW-1:0] xs;
    logic [MW-1:0] mag;
    logic [MW-1:0] sum;
    logic [RW-1:0] ext;

    // Magnitude of the sample, plus half a step, with the fraction dropped
    always_comb begin
        neg = sample_i[IN_W-1];
        xs  = {sample_i[IN_W-1], sample_i};
        mag = neg ? (~xs + MW'(1)) : xs;
        sum = mag + MW'(HALF);
        ext = {1'b0, sum[MW-1:FRAC_W]};
    end

    // Put the sign back on the rounded magnitude
    assign rnd_o = neg ? (~ext + RW'(1)) : ext;

    // Rounding error must stay within half a step
    always_comb begin
        longint diff;
        diff = longint'($signed(rnd_o)) * longint'(2 ** FRAC_W) - longint'($signed(sample_i));
        if (!$isunknown(sample_i)) begin
            AST_ROUND_HALF_STEP: assert (diff <= longint'(HALF) && diff >= -longint'(HALF)); // R3
        end
    end
endmodule

// File: rtl/sq_clamp.sv
// Module: sq_clamp
// Clamps a wide signed rounded value to ±(2^(OUT_W-1)-1). The flag is raised
// when the value reaches a limit, not only when it passes it.
// Assumes RW > OUT_W.
module sq_clamp #(
    parameter int RW    = 26,
    parameter int OUT_W = 16
) (
    input  logic [RW-1:0]    rnd_i,
    output logic [OUT_W-1:0] code_o,
    output logic             sat_o
);
    localparam logic signed [RW-1:0] POS_LIM = RW'(2 ** (OUT_W - 1) - 1);
    localparam logic signed [RW-1:0] NEG_LIM = -POS_LIM;

    logic signed [RW-1:0] r;

    // Compare against both limits and select the clamped code
    always_comb begin
        r = $signed(rnd_i);
        if (r >= POS_LIM) begin
            code_o = POS_LIM[OUT_W-1:0];
            sat_o  = 1'b1;
        end else if (r <= NEG_LIM) begin
            code_o = NEG_LIM[OUT_W-1:0];
            sat_o  = 1'b1;
        end else begin
            code_o = r[OUT_W-1:0];
            sat_o  = 1'b0;
        end
    end

    // The clamped code must lie within the symmetric limits
    always_comb begin
        if (!$isunknown(rnd_i)) begin
            AST_CLAMP_RANGE: assert ($signed(code_o) <= $signed(POS_LIM[OUT_W-1:0]) &&
                                     $signed(code_o) >= $signed(NEG_LIM[OUT_W-1:0])); // R2
        end
    end
endmodule

// File: rtl/sq_out_reg.sv
// Module: sq_out_reg
// Output register stage. It loads the code and flag when the strobe is high
// and holds them otherwise. The valid output follows the strobe one cycle
// later. Reset is synchronous and active low.
module sq_out_reg #(
    parameter int OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_i,
    input  logic [OUT_W-1:0] code_i,
    input  logic             sat_i,
    output logic             vld_o,
    output logic [OUT_W-1:0] code_o,
    output logic             sat_o
);
    localparam logic [OUT_W-1:0] POS_C = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] NEG_C = {1'b1, {(OUT_W-2){1'b0}}, 1'b1};
    localparam logic [OUT_W-1:0] MIN_C = {1'b1, {(OUT_W-1){1'b0}}};

    // Load on strobe, hold otherwise, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o  <= 1'b0;
            code_o <= '0;
            sat_o  <= 1'b0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                code_o <= code_i;
                sat_o  <= sat_i;
            end
        end
    end

    AST_NO_MIN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        code_o != MIN_C); // R2
    AST_SAT_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        sat_o |-> (code_o == POS_C || code_o == NEG_C)); // R4
    AST_LIMIT_RAISES_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && (code_o == POS_C || code_o == NEG_C)) |-> sat_o); // R5
    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |=> vld_o); // R7
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> (!vld_o && $stable(code_o) && $stable(sat_o))); // R8
endmodule

// File: rtl/sym_sat_quantiser.sv
// Module: sym_sat_quantiser
// Top of the quantiser: round, then symmetric clamp, then output register.
// Assumes the sample is scaled so that one integer unit is one code step.
// Widths come from sq_pkg.
module sym_sat_quantiser
    import sq_pkg::*;
#(
    parameter int IN_W   = SQ_IN_W,
    parameter int FRAC_W = SQ_FRAC_W,
    parameter int OUT_W  = SQ_OUT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_sample,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_code,
    output logic             out_sat
);
    localparam int RW = IN_W - FRAC_W + 2;

    logic [RW-1:0]    rnd;
    logic [OUT_W-1:0] code_c;
    logic             sat_c;

    sq_round #(.IN_W(IN_W), .FRAC_W(FRAC_W), .RW(RW)) u_round (
        .sample_i (in_sample),
        .rnd_o    (rnd)
    );

    sq_clamp #(.RW(RW), .OUT_W(OUT_W)) u_clamp (
        .rnd_i  (rnd),
        .code_o (code_c),
        .sat_o  (sat_c)
    );

    sq_out_reg #(.OUT_W(OUT_W)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (in_valid),
        .code_i (code_c),
        .sat_i  (sat_c),
        .vld_o  (out_valid),
        .code_o (out_code),
        .sat_o  (out_sat)
    );
endmodule

// File: tb/sym_sat_quantiser_bench.sv
module sym_sat_quantiser_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_sample = 32'd0;
    logic        out_valid;
    logic [15:0] out_code;
    logic        out_sat;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    logic [31:0] lfsr = 32'h1234_5678;

    always #2 clk = ~clk;

    sym_sat_quantiser u_sym_sat_quantiser (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .out_valid (out_valid),
        .out_code  (out_code),
        .out_sat   (out_sat)
    );

    // Reference: round half away from zero, then symmetric inclusive clamp
    function automatic void model(input logic [31:0] x, output logic [15:0] c, output logic s);
        longint v;
        longint r;
        v = longint'($signed(x));
        if (v >= 0) r = (v + 128) / 256;
        else        r = -((-v + 128) / 256);
        if (r >= 32767)       begin c = 16'd32767;  s = 1'b1; end
        else if (r <= -32767) begin c = 16'h8001;   s = 1'b1; end
        else                  begin c = r[15:0];    s = 1'b0; end
    endfunction

    task automatic check(input string tag, input bit ok, input logic [15:0] ac, input logic as_, input logic av,
                         input logic [15:0] ec, input logic es, input logic ev);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: code=%0d sat=%0b valid=%0b expected code=%0d sat=%0b valid=%0b",
                     tag, $signed(ac), as_, av, $signed(ec), es, ev);
        end
    endtask

    task automatic apply(input logic [31:0] x, input string tag);
        logic [15:0] ec;
        logic        es;
        model(x, ec, es);
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = x;
        @(negedge clk);
        check(tag, out_code === ec && out_sat === es && out_valid === 1'b1 && out_code !== 16'h8000,
              out_code, out_sat, out_valid, ec, es, 1'b1);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] hc;
        logic        hs;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 reset", out_code === 16'd0 && out_sat === 1'b0 && out_valid === 1'b0,
              out_code, out_sat, out_valid, 16'd0, 1'b0, 1'b0);
        rst_n = 1'b1;

        // R1: every fraction pattern around zero
        for (int i = -2048; i <= 2048; i++) apply(32'(i), "R1 near zero");
        // R3: half-step ties, both signs
        for (int k = -300; k <= 300; k++) apply(32'(k * 256 + 128), "R3 tie");
        apply(32'h0000_0280, "R3 +2.5");
        apply(32'hFFFF_FD80, "R3 -2.5");
        // R4: window around the positive threshold
        for (int i = -1024; i <= 1024; i++) apply(32'(32767 * 256 + i), "R4 pos limit");
        apply(32'(32766 * 256 + 128), "R4 rounds onto limit");
        // R5: window around the negative threshold
        for (int i = -1024; i <= 1024; i++) apply(32'(-32767 * 256 + i), "R5 neg limit");
        apply(32'(-32766 * 256 - 128), "R5 rounds onto limit");
        // R2: extremes of the input range
        apply(32'h7FFF_FFFF, "R2 max input");
        apply(32'h8000_0000, "R2 min input");
        apply(32'h8000_0001, "R2 min+1 input");
        apply(32'(-32768 * 256), "R2 -32768 exact");
        // R6: pseudo-random samples, mostly in range
        for (int i = 0; i < 3000; i++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            apply((i % 4 == 0) ? lfsr : {{9{lfsr[22]}}, lfsr[22:0]}, "R6 random");
        end

        // R8: idle edges hold code and flag
        apply(32'(1234 * 256), "R7 load");
        model(32'(1234 * 256), hc, hs);
        in_valid  = 1'b0;
        in_sample = 32'h7FFF_FFFF;
        @(negedge clk);
        check("R8 idle hold", out_valid === 1'b0 && out_code === hc && out_sat === hs,
              out_code, out_sat, out_valid, hc, hs, 1'b0);
        @(negedge clk);
        check("R8 idle hold 2", out_valid === 1'b0 && out_code === hc && out_sat === hs,
              out_code, out_sat, out_valid, hc, hs, 1'b0);

        // R9: reset in mid-run clears a saturated result
        apply(32'h7FFF_FFFF, "R4 before reset");
        in_valid = 1'b1;
        rst_n    = 1'b0;
        @(negedge clk);
        check("R9 mid reset", out_code === 16'd0 && out_sat === 1'b0 && out_valid === 1'b0,
              out_code, out_sat, out_valid, 16'd0, 1'b0, 1'b0);
        rst_n    = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule